// File: doc/BRIEF.md
# Three-Wire Tuner Control Register Bank

This block is a serial slave for a radio tuner front end. A microcontroller writes it over three lines: an enable, a bit clock and a data line. While enable is high, every rising edge of the bit clock shifts one data bit into the block, least significant bit first. The block counts the bits of the frame. When enable drops, the whole frame is applied to the internal register set at once. A 16-bit frame is a fast tuning write that loads the N divider. A 24-bit frame carries an address in its third byte, and that address picks which register group the first two bytes load.

The three bus lines are asynchronous to the system clock, so each passes through a synchronizer before any edge detection. The block drives the digital control words only: the N and R divider values, the four switch controls (0 = switch on, pulled to ground), the FM/AM mode of the alignment DACs, the gain and offset codes of two alignment DACs, the 3-bit code of a third DAC, the oscillator-buffer enable, a one-hot pump-current select, and the crystal-load capacitor code with its load in 0.5 pF units. The DAC, switch, oscillator and pump circuits themselves are not part of it.

Top module: `tuner_ctl_bank`

## Requirements
- R1: After synchronous reset the outputs are: sw_on_n = 4'hF (all switches off), am_mode = 0, all DAC gain, offset and third-DAC codes 0, oscbuf_en = 0, pump_sel = 4'b0001, xtal_code = 0, xtal_load_hp = 0, ndiv = 0 and rdiv = 0.
- R2: Bits arrive least significant first. A frame of exactly 16 bits loads ndiv with the frame, so the first bit has weight 2^0 and the sixteenth has weight 2^15.
- R3: In a 24-bit frame, byte 1 is bits 0-7, byte 2 is bits 8-15 and byte 3 is bits 16-23. Address = byte3[2:0]. Address 0 loads rdiv = {byte2, byte1}.
- R4: Address 1 loads dac1_gain = byte1, dac1_ofs = byte2[5:0] and am_mode = byte2[6] (0 = FM, 1 = AM).
- R5: Address 2 loads dac2_gain = byte1 and dac2_ofs = byte2[5:0]. The other bits of byte 2 change nothing.
- R6: Address 3 loads sw_on_n = byte1[3:0] (bit value 0 = switch on, 1 = off), oscbuf_en = NOT byte1[4], dac3_code = byte1[7:5] and the pump code = byte2[1:0]. The pump code drives pump_sel one-hot, with bit index equal to the code (00, 01, 10, 11 select 25, 100, 500 and 2000 uA).
- R7: Address 4 loads xtal_code = byte1. xtal_load_hp = xtal_code[6:0] + 16 * xtal_code[7], which is the load in 0.5 pF steps, with the top bit adding a fixed 8 pF segment.
- R8: A frame whose bit count is neither 16 nor 24 changes no output. This includes frames longer than 24 bits. A 24-bit frame with address 5, 6 or 7 also changes no output.
- R9: Bit-clock edges while enable is low shift nothing and change no output. The bit count restarts from zero each time enable rises.
- R10: No output changes while a frame is still open. A committed frame appears on the outputs on the fourth clock edge after the first edge that samples enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus enable, active high, asynchronous |
| bus_clk | input | 1 | Bus bit clock, asynchronous |
| bus_dat | input | 1 | Bus serial data, asynchronous |
| sw_on_n | output | 4 | Switch controls, 0 = on |
| am_mode | output | 1 | Alignment DAC mode, 0 = FM, 1 = AM |
| dac1_gain | output | 8 | First alignment DAC gain code |
| dac1_ofs | output | 6 | First alignment DAC offset code |
| dac2_gain | output | 8 | Second alignment DAC gain code |
| dac2_ofs | output | 6 | Second alignment DAC offset code |
| dac3_code | output | 3 | Third DAC level code |
| oscbuf_en | output | 1 | Oscillator buffer enable |
| pump_sel | output | 4 | One-hot pump current select |
| xtal_code | output | 8 | Crystal-load capacitor code |
| xtal_load_hp | output | 8 | Crystal load in 0.5 pF units |
| ndiv | output | 16 | N divider value |
| rdiv | output | 16 | R divider value |

## Verification
A committed frame shows on the outputs on the fourth system-clock edge after enable is first sampled low. Two of those edges are spent in the synchronizer, one in edge detection and frame capture, and one in the register write. The bench therefore waits six cycles after dropping enable before it compares any output. One directed case also samples one edge after the drop to confirm the old value is still held, and samples during an open frame to confirm nothing has moved yet. Bus edges are spaced four system cycles apart, so each of them is resolved well before the next.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  localparam int BYTE_W   = 8;
  localparam int SHORT_W  = 2 * BYTE_W;
  localparam int FRAME_W  = 3 * BYTE_W;
  localparam int ADDR_W   = 3;
  localparam int CNT_W    = 6;
  localparam int SW_N     = 4;
  localparam int OFS_W    = 6;
  localparam int D3_W     = 3;
  localparam int PUMP_W   = 2;
  localparam int PUMP_N   = 1 << PUMP_W;
  localparam int XSEG_HP  = 16;

  typedef enum logic [ADDR_W-1:0] {
    ADR_RDIV = 3'd0,
    ADR_DAC1 = 3'd1,
    ADR_DAC2 = 3'd2,
    ADR_CTRL = 3'd3,
    ADR_XTAL = 3'd4
  } tcb_addr_e;

  typedef struct packed {
    logic [SW_N-1:0]    sw_on_n;
    logic               am_mode;
    logic [BYTE_W-1:0]  dac1_gain;
    logic [OFS_W-1:0]   dac1_ofs;
    logic [BYTE_W-1:0]  dac2_gain;
    logic [OFS_W-1:0]   dac2_ofs;
    logic [D3_W-1:0]    dac3_code;
    logic               oscbuf_en;
    logic [PUMP_N-1:0]  pump_sel;
    logic [BYTE_W-1:0]  xtal_code;
    logic [BYTE_W-1:0]  xtal_load_hp;
    logic [SHORT_W-1:0] ndiv;
    logic [SHORT_W-1:0] rdiv;
  } tcb_regs_t;

  function automatic logic [PUMP_N-1:0] pump_onehot(input logic [PUMP_W-1:0] code);
    logic [PUMP_N-1:0] v;
    v = '0;
    for (int i = 0; i < PUMP_N; i++)
      if (code == PUMP_W'(i)) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [BYTE_W-1:0] xtal_halfpf(input logic [BYTE_W-1:0] code);
    logic [BYTE_W-1:0] base;
    base = {1'b0, code[BYTE_W-2:0]};
    return code[BYTE_W-1] ? base + BYTE_W'(XSEG_HP) : base;
  endfunction
endpackage

// File: rtl/tcb_sync.sv
module tcb_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[g] <= '0;
      else if (g == 0) st[g] <= d;
      else st[g] <= st[(g == 0) ? 0 : g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/tcb_deser.sv
module tcb_deser
  import tcb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en_s,
  input  logic               sclk_s,
  input  logic               dat_s,
  output logic               frm_vld,
  output logic [CNT_W-1:0]   frm_len,
  output logic [FRAME_W-1:0] frm_word
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic               en_q, sclk_q;
  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   cnt;
  logic               en_rise, en_fall, bit_stb;

  assign en_rise = en_s & ~en_q;
  assign en_fall = ~en_s & en_q;
  assign bit_stb = en_s & en_q & sclk_s & ~sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      sclk_q   <= 1'b0;
      sr       <= '0;
      cnt      <= '0;
      frm_vld  <= 1'b0;
      frm_len  <= '0;
      frm_word <= '0;
    end else begin
      en_q    <= en_s;
      sclk_q  <= sclk_s;
      frm_vld <= 1'b0;
      if (en_rise) begin
        cnt <= '0;
      end else if (bit_stb) begin
        sr <= {dat_s, sr[FRAME_W-1:1]};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
      if (en_fall) begin
        frm_vld  <= 1'b1;
        frm_len  <= cnt;
        frm_word <= sr;
      end
    end
  end
endmodule

// File: rtl/tcb_regfile.sv
module tcb_regfile
  import tcb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               frm_vld,
  input  logic [CNT_W-1:0]   frm_len,
  input  logic [FRAME_W-1:0] frm_word,
  output tcb_regs_t          regs
);
  logic               is_short, is_long;
  logic [SHORT_W-1:0] payload;
  logic [BYTE_W-1:0]  b1, b2;
  logic [ADDR_W-1:0]  addr;

  assign is_short = frm_vld && (frm_len == CNT_W'(SHORT_W));
  assign is_long  = frm_vld && (frm_len == CNT_W'(FRAME_W));
  assign payload  = is_short ? frm_word[FRAME_W-1 -: SHORT_W] : frm_word[SHORT_W-1:0];
  assign b1       = payload[BYTE_W-1:0];
  assign b2       = payload[SHORT_W-1:BYTE_W];
  assign addr     = frm_word[SHORT_W +: ADDR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      regs          <= '0;
      regs.sw_on_n  <= '1;
      regs.pump_sel <= pump_onehot('0);
    end else if (is_short) begin
      regs.ndiv <= payload;
    end else if (is_long) begin
      case (addr)
        ADR_RDIV: regs.rdiv <= payload;
        ADR_DAC1: begin
          regs.dac1_gain <= b1;
          regs.dac1_ofs  <= b2[OFS_W-1:0];
          regs.am_mode   <= b2[OFS_W];
        end
        ADR_DAC2: begin
          regs.dac2_gain <= b1;
          regs.dac2_ofs  <= b2[OFS_W-1:0];
        end
        ADR_CTRL: begin
          regs.sw_on_n   <= b1[SW_N-1:0];
          regs.oscbuf_en <= ~b1[SW_N];
          regs.dac3_code <= b1[BYTE_W-1 -: D3_W];
          regs.pump_sel  <= pump_onehot(b2[PUMP_W-1:0]);
        end
        ADR_XTAL: begin
          regs.xtal_code    <= b1;
          regs.xtal_load_hp <= xtal_halfpf(b1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tuner_ctl_bank.sv
module tuner_ctl_bank
  import tcb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_en,
  input  logic               bus_clk,
  input  logic               bus_dat,
  output logic [SW_N-1:0]    sw_on_n,
  output logic               am_mode,
  output logic [BYTE_W-1:0]  dac1_gain,
  output logic [OFS_W-1:0]   dac1_ofs,
  output logic [BYTE_W-1:0]  dac2_gain,
  output logic [OFS_W-1:0]   dac2_ofs,
  output logic [D3_W-1:0]    dac3_code,
  output logic               oscbuf_en,
  output logic [PUMP_N-1:0]  pump_sel,
  output logic [BYTE_W-1:0]  xtal_code,
  output logic [BYTE_W-1:0]  xtal_load_hp,
  output logic [SHORT_W-1:0] ndiv,
  output logic [SHORT_W-1:0] rdiv
);
  logic [2:0]         bus_s;
  logic               frm_vld;
  logic [CNT_W-1:0]   frm_len;
  logic [FRAME_W-1:0] frm_word;
  tcb_regs_t          regs;

  tcb_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bus_en, bus_clk, bus_dat}),
    .q   (bus_s)
  );

  tcb_deser i_deser (
    .clk      (clk),
    .rst      (rst),
    .en_s     (bus_s[2]),
    .sclk_s   (bus_s[1]),
    .dat_s    (bus_s[0]),
    .frm_vld  (frm_vld),
    .frm_len  (frm_len),
    .frm_word (frm_word)
  );

  tcb_regfile i_regs (
    .clk      (clk),
    .rst      (rst),
    .frm_vld  (frm_vld),
    .frm_len  (frm_len),
    .frm_word (frm_word),
    .regs     (regs)
  );

  assign sw_on_n      = regs.sw_on_n;
  assign am_mode      = regs.am_mode;
  assign dac1_gain    = regs.dac1_gain;
  assign dac1_ofs     = regs.dac1_ofs;
  assign dac2_gain    = regs.dac2_gain;
  assign dac2_ofs     = regs.dac2_ofs;
  assign dac3_code    = regs.dac3_code;
  assign oscbuf_en    = regs.oscbuf_en;
  assign pump_sel     = regs.pump_sel;
  assign xtal_code    = regs.xtal_code;
  assign xtal_load_hp = regs.xtal_load_hp;
  assign ndiv         = regs.ndiv;
  assign rdiv         = regs.rdiv;
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker
  import tcb_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               frm_vld,
  input logic [CNT_W-1:0]   frm_len,
  input logic [FRAME_W-1:0] frm_word,
  input logic [PUMP_N-1:0]  pump_sel,
  input logic [BYTE_W-1:0]  xtal_load_hp,
  input logic [SHORT_W-1:0] ndiv,
  input tcb_regs_t          regs
);
  logic bad_len;
  assign bad_len = (frm_len != CNT_W'(SHORT_W)) && (frm_len != CNT_W'(FRAME_W));

  AST_PUMP_ONEHOT: assert property (@(posedge clk) disable iff (rst) $countones(pump_sel) == 1); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !frm_vld |=> $stable(regs)); // R10
  AST_BAD_LEN_DROP: assert property (@(posedge clk) disable iff (rst) (frm_vld && bad_len) |=> $stable(regs)); // R8
  AST_SHORT_NDIV: assert property (@(posedge clk) disable iff (rst)
    (frm_vld && frm_len == CNT_W'(SHORT_W)) |=> ndiv == $past(frm_word[FRAME_W-1 -: SHORT_W])); // R2
  AST_XTAL_RANGE: assert property (@(posedge clk) disable iff (rst) xtal_load_hp <= 8'd143); // R7
endmodule

bind tuner_ctl_bank tcb_checker i_chk (
  .clk          (clk),
  .rst          (rst),
  .frm_vld      (frm_vld),
  .frm_len      (frm_len),
  .frm_word     (frm_word),
  .pump_sel     (pump_sel),
  .xtal_load_hp (xtal_load_hp),
  .ndiv         (ndiv),
  .regs         (regs)
);

// File: tb/test_tuner_ctl_bank.sv
module test_tuner_ctl_bank;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_en = 1'b0, bus_clk = 1'b0, bus_dat = 1'b0;
  logic [3:0]  sw_on_n;
  logic        am_mode, oscbuf_en;
  logic [7:0]  dac1_gain, dac2_gain, xtal_code, xtal_load_hp;
  logic [5:0]  dac1_ofs, dac2_ofs;
  logic [2:0]  dac3_code;
  logic [3:0]  pump_sel;
  logic [15:0] ndiv, rdiv;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tuner_ctl_bank i_tuner_ctl_bank (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_clk(bus_clk), .bus_dat(bus_dat),
    .sw_on_n(sw_on_n), .am_mode(am_mode), .dac1_gain(dac1_gain), .dac1_ofs(dac1_ofs),
    .dac2_gain(dac2_gain), .dac2_ofs(dac2_ofs), .dac3_code(dac3_code),
    .oscbuf_en(oscbuf_en), .pump_sel(pump_sel), .xtal_code(xtal_code),
    .xtal_load_hp(xtal_load_hp), .ndiv(ndiv), .rdiv(rdiv)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [63:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      bus_dat = bits[i];
      tick(HALF_BIT);
      bus_clk = 1'b1;
      tick(HALF_BIT);
      bus_clk = 1'b0;
    end
  endtask

  task automatic send(input logic [63:0] bits, input int n);
    bus_en = 1'b1;
    tick(HALF_BIT);
    shift_bits(bits, n);
    tick(HALF_BIT);
    bus_en = 1'b0;
    tick(6);
  endtask

  function automatic logic [63:0] f24(input logic [2:0] a, input logic [7:0] b2, input logic [7:0] b1);
    return {40'd0, 5'd0, a, b2, b1};
  endfunction

  task automatic t_reset;
    chk("R1 sw_on_n", 32'(sw_on_n), 32'hF);
    chk("R1 pump_sel", 32'(pump_sel), 32'h1);
    chk("R1 oscbuf_en/am_mode", {oscbuf_en, am_mode}, 32'h0);
    chk("R1 dividers", {ndiv, rdiv}, 32'h0);
    chk("R1 dac codes", {dac1_gain, dac2_gain, dac1_ofs, dac2_ofs, dac3_code}, 32'h0);
    chk("R1 xtal", {xtal_code, xtal_load_hp}, 32'h0);
  endtask

  task automatic t_ndiv;
    send(64'h0001, 16);
    chk("R2 ndiv weight 2^0", 32'(ndiv), 32'h0001);
    send(64'h8000, 16);
    chk("R2 ndiv weight 2^15", 32'(ndiv), 32'h8000);
    // R10: open frame holds outputs; commit lands after the sync delay
    bus_en = 1'b1;
    tick(HALF_BIT);
    shift_bits(64'hA5C3, 16);
    tick(HALF_BIT);
    chk("R10 held while enable high", 32'(ndiv), 32'h8000);
    bus_en = 1'b0;
    tick(1);
    chk("R10 held one edge after drop", 32'(ndiv), 32'h8000);
    tick(5);
    chk("R2 ndiv pattern", 32'(ndiv), 32'hA5C3);
    chk("R10 rdiv untouched", 32'(rdiv), 32'h0);
  endtask

  task automatic t_rdiv;
    send(f24(3'd0, 8'h12, 8'h34), 24);
    chk("R3 rdiv", 32'(rdiv), 32'h1234);
    chk("R3 ndiv untouched", 32'(ndiv), 32'hA5C3);
  endtask

  task automatic t_dac1;
    send(f24(3'd1, 8'h6D, 8'h9B), 24);
    chk("R4 dac1_gain", 32'(dac1_gain), 32'h9B);
    chk("R4 dac1_ofs", 32'(dac1_ofs), 32'h2D);
    chk("R4 am_mode", 32'(am_mode), 32'h1);
  endtask

  task automatic t_dac2;
    send(f24(3'd2, 8'hD5, 8'h3C), 24);
    chk("R5 dac2 gain/ofs", {dac2_gain, 2'b00, dac2_ofs}, 32'h3C15);
    chk("R5 dac1/mode untouched", {am_mode, dac1_gain}, 32'h19B);
  endtask

  task automatic t_ctrl;
    send(f24(3'd3, 8'h02, 8'hAA), 24);
    chk("R6 sw_on_n", 32'(sw_on_n), 32'hA);
    chk("R6 oscbuf_en", 32'(oscbuf_en), 32'h1);
    chk("R6 dac3_code", 32'(dac3_code), 32'h5);
    chk("R6 pump_sel code 2", 32'(pump_sel), 32'h4);
    send(f24(3'd3, 8'hFF, 8'h15), 24);
    chk("R6 sw/osc/dac3 second", {sw_on_n, oscbuf_en, dac3_code}, {24'd0, 4'h5, 1'b0, 3'd0});
    chk("R6 pump_sel code 3", 32'(pump_sel), 32'h8);
  endtask

  task automatic t_xtal;
    send(f24(3'd4, 8'h00, 8'h85), 24);
    chk("R7 xtal 0x85", {xtal_code, xtal_load_hp}, {16'd0, 8'h85, 8'd21});
    send(f24(3'd4, 8'h00, 8'h7F), 24);
    chk("R7 xtal 0x7F", {xtal_code, xtal_load_hp}, {16'd0, 8'h7F, 8'd127});
    send(f24(3'd4, 8'h00, 8'hFF), 24);
    chk("R7 xtal 0xFF", {xtal_code, xtal_load_hp}, {16'd0, 8'hFF, 8'd143});
  endtask

  task automatic t_discard;
    send(64'hFFFFF, 20);
    chk("R8 20-bit dropped", 32'(ndiv), 32'hA5C3);
    send(64'hFF, 8);
    chk("R8 8-bit dropped", {dac1_gain, xtal_code}, 32'h9BFF);
    send(64'hFF_FFFF_FFFF, 40);
    chk("R8 40-bit dropped", {ndiv, rdiv}, 32'hA5C3_1234);
    send(f24(3'd6, 8'h55, 8'h55), 24);
    chk("R8 address 6 dropped", {rdiv, dac1_gain, dac2_gain}, 32'h1234_9B3C);
    send(f24(3'd7, 8'h00, 8'h00), 24);
    chk("R8 address 7 dropped", {sw_on_n, pump_sel, xtal_code}, {16'd0, 4'h5, 4'h8, 8'hFF});
  endtask

  task automatic t_idle_clk;
    for (int i = 0; i < 24; i++) begin
      bus_dat = 1'b1;
      tick(HALF_BIT);
      bus_clk = 1'b1;
      tick(HALF_BIT);
      bus_clk = 1'b0;
    end
    tick(6);
    chk("R9 idle clocks ignored", {ndiv, rdiv}, 32'hA5C3_1234);
    send(64'h7, 3);
    send(64'h1357, 16);
    chk("R9 count restarts", 32'(ndiv), 32'h1357);
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    tick(2);
    t_reset();
    t_ndiv();
    t_rdiv();
    t_dac1();
    t_dac2();
    t_ctrl();
    t_xtal();
    t_discard();
    t_idle_clk();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule